// File: doc/BRIEF.md
# SDRAM Four-Word Read Sequencer

This block serves a 16-byte read from a host bus by driving a synchronous DRAM whose data path is 32 bits wide, built from four byte-wide devices and programmed for single-word bursts. For each accepted request it issues one row activation and then four back-to-back column reads. The last of these reads carries auto-precharge. It forms the row and column addresses on a 16-pin multiplexed address bus. It captures the four returned words after a fixed CAS latency and hands them to the requester one per cycle, with an index and a completion pulse.

Once the final read is issued, the accessed bank is locked for a programmable number of precharge-wait cycles. The wait length is chosen per request and latched when the request is taken. A request to the same bank is held off until the lock expires. A request to any other bank is taken as soon as the command sequence has finished, even while the lock is still running. A busy flag covers the whole command sequence, the outstanding data and the lock.

Top module: `sdr_rd_top`

## Requirements
- R1: After reset the command pins show NOP (chip select, RAS, CAS and WE all high), `busy` is low, `req_ready` is high, and `word_valid` and `done` are low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle the command is ACTIVATE (chip select low, RAS low, CAS high, WE high) and `sd_addr[15:0]` equals host address bits 23..8, so pins 13..12 carry the bank number from host bits 21..20.
- R3: The four cycles directly after ACTIVATE each carry a READ command (chip select low, RAS high, CAS low, WE high).
- R4: In the column cycle for beat j (0..3), `sd_addr` is {host[23:22], host[13], P, host[11:4], j as 2 bits, 2'b00}. P is pin 12, the auto-precharge flag, and is high only for j = 3. Host address bits 3..0 of the request are ignored.
- R5: The data word present on `sd_rdata` CAS_LAT cycles after a READ is presented on `word_data`, with `word_valid` high and `word_idx` = j, CAS_LAT+1 cycles after that READ. The four words of an access come in consecutive cycles.
- R6: `done` is high for exactly one cycle, the cycle in which word index 3 is presented.
- R7: The precharge wait W is `req_tpc`+1 cycles (00 gives 1, 11 gives 4) and is latched when the request is taken; later changes to `req_tpc` do not affect it. A request to the same bank gets its ACTIVATE no earlier than W+1 cycles after the auto-precharge READ cycle.
- R8: A request to a different bank (host bits 21..20 differ) that is already waiting gets its ACTIVATE two cycles after the auto-precharge READ cycle, whatever the lock.
- R9: `busy` is high from the ACTIVATE cycle through the `done` cycle and through the lock. It falls once all of these have ended. `req_ready` is low while a sequence is in progress.
- R10: In every cycle that is not ACTIVATE or READ, the command is NOP with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request present |
| req_addr | input | 24 | Host byte address; bits 3..0 ignored |
| req_tpc | input | TPC_W | Precharge wait code, wait = code + 1 cycles |
| req_ready | output | 1 | Request can be taken this cycle |
| busy | output | 1 | Access or precharge lock in progress |
| sd_cs_n | output | 1 | Memory chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low (high for all commands here) |
| sd_addr | output | 16 | Multiplexed row/column address pins |
| sd_rdata | input | DATA_W | Read data from the memory |
| word_valid | output | 1 | A captured word is presented |
| word_idx | output | 2 | Index of the presented word within the access |
| word_data | output | DATA_W | Presented word |
| done | output | 1 | Last word of the access presented |

## Verification
ACTIVATE is due one cycle after the accepting edge. The four READs follow in the next four cycles, and each word is due CAS_LAT+1 cycles after its own READ. The bench samples on the falling edge and compares each observation with the cycle number it predicts from those counts. A same-bank ACTIVATE is due at the auto-precharge cycle plus the latched wait plus one, and a different-bank ACTIVATE at that cycle plus two. The bench predicts the exact ACTIVATE cycle from its own record of the previous access, as the latest of the request cycle, the sequence end and the bank lock. Expected words are queued with their due cycle when each READ is checked, and a word that comes late, early or not at all is reported.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    localparam int HOST_AW     = 24;
    localparam int MEM_AW      = 16;
    localparam int BURST_WORDS = 4;
    localparam int BEAT_W      = $clog2(BURST_WORDS);
    localparam int BANK_W      = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_COL  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_ACT  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_READ = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};

    function automatic logic [MEM_AW-1:0] row_pins(input logic [HOST_AW-1:0] a);
        return a[23:8];
    endfunction

    function automatic logic [MEM_AW-1:0] col_pins(input logic [HOST_AW-1:0] a,
                                                   input logic [BEAT_W-1:0]  beat,
                                                   input logic               apre);
        return {a[23:22], a[13], apre, a[11:4], beat, a[1:0]};
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [HOST_AW-1:0] a);
        return a[21:20];
    endfunction

endpackage

// File: rtl/sdr_rd_seq.sv
module sdr_rd_seq
    import sdr_rd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [HOST_AW-1:0]  start_addr,
    output logic                idle,
    output logic                act_now,
    output logic                rd_now,
    output logic                ap_now,
    output logic [BANK_W-1:0]   cur_bank,
    output sdr_cmd_t            cmd_o,
    output logic [MEM_AW-1:0]   addr_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_WORDS - 1);

    seq_state_e          state_q;
    logic [BEAT_W-1:0]   beat_q;
    logic [HOST_AW-1:0]  addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_ACT;
                        addr_q  <= {start_addr[HOST_AW-1:4], 4'b0000};
                        beat_q  <= '0;
                    end
                end
                ST_ACT: begin
                    state_q <= ST_COL;
                    beat_q  <= '0;
                end
                ST_COL: begin
                    if (beat_q == LAST_BEAT) begin
                        state_q <= ST_IDLE;
                    end
                    beat_q <= beat_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle     = (state_q == ST_IDLE);
        act_now  = (state_q == ST_ACT);
        rd_now   = (state_q == ST_COL);
        ap_now   = rd_now && (beat_q == LAST_BEAT);
        cur_bank = bank_of(addr_q);
        cmd_o    = CMD_NOP;
        addr_o   = '0;
        if (act_now) begin
            cmd_o  = CMD_ACT;
            addr_o = row_pins(addr_q);
        end else if (rd_now) begin
            cmd_o  = CMD_READ;
            addr_o = col_pins(addr_q, beat_q, ap_now);
        end
    end

    a_r2_act_row: assert property (@(posedge clk) disable iff (rst)
        start |=> (cmd_o == CMD_ACT) && (addr_o == row_pins($past(start_addr))));

    a_r3_read_after_act: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT) |=> (cmd_o == CMD_READ) && (addr_o[3:2] == '0));

    a_r4_apre_ends_seq: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == CMD_READ) && addr_o[12]) |=> (cmd_o == CMD_NOP));

    a_r10_legal_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_NOP) || (cmd_o == CMD_ACT) || (cmd_o == CMD_READ));

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture
    import sdr_rd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CAS_LAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_now,
    input  logic [DATA_W-1:0]  rdata,
    output logic               word_valid,
    output logic [BEAT_W-1:0]  word_idx,
    output logic [DATA_W-1:0]  word_data,
    output logic               done,
    output logic               pending
);

    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_WORDS - 1);

    logic [CAS_LAT-1:0]  lat_q;
    logic [BEAT_W-1:0]   cnt_q;
    logic                take;

    generate
        if (CAS_LAT == 1) begin : g_lat_one
            always_ff @(posedge clk) begin
                if (rst) lat_q <= '0;
                else     lat_q <= rd_now;
            end
        end else begin : g_lat_many
            always_ff @(posedge clk) begin
                if (rst) lat_q <= '0;
                else     lat_q <= {lat_q[CAS_LAT-2:0], rd_now};
            end
        end
    endgenerate

    assign take = lat_q[CAS_LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            word_valid <= 1'b0;
            word_idx   <= '0;
            word_data  <= '0;
            done       <= 1'b0;
        end else begin
            word_valid <= take;
            done       <= take && (cnt_q == LAST_IDX);
            if (take) begin
                word_idx  <= cnt_q;
                word_data <= rdata;
                cnt_q     <= cnt_q + 1'b1;
            end
        end
    end

    assign pending = |lat_q;

    a_r6_done_on_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (word_valid && (word_idx == LAST_IDX)));

    a_r5_words_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (word_valid && (word_idx != '0)) |->
            ($past(word_valid) && ($past(word_idx) == BEAT_W'(word_idx - 1'b1))));

endmodule

// File: rtl/sdr_bank_guard.sv
module sdr_bank_guard
    import sdr_rd_pkg::*;
#(
    parameter int TPC_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TPC_W-1:0]   start_tpc,
    input  logic               ap_now,
    input  logic               act_now,
    input  logic [BANK_W-1:0]  cur_bank,
    input  logic [BANK_W-1:0]  req_bank,
    output logic               blocked,
    output logic               active
);

    localparam int TW = TPC_W + 1;

    logic [TPC_W-1:0]  tpc_hold_q;
    logic [TW-1:0]     timer_q;
    logic [BANK_W-1:0] lock_bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tpc_hold_q  <= '0;
            timer_q     <= '0;
            lock_bank_q <= '0;
        end else begin
            if (start) begin
                tpc_hold_q <= start_tpc;
            end
            if (ap_now) begin
                timer_q     <= TW'(tpc_hold_q) + 1'b1;
                lock_bank_q <= cur_bank;
            end else if (timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    assign active  = (timer_q != '0);
    assign blocked = (timer_q > TW'(1)) && (req_bank == lock_bank_q);

    a_r7_locked_bank_quiet: assert property (@(posedge clk) disable iff (rst)
        (act_now && (cur_bank == lock_bank_q)) |-> (timer_q == '0));

    a_r7_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
        (active && !ap_now) |=> (timer_q == TW'($past(timer_q) - 1'b1)));

endmodule

// File: rtl/sdr_rd_top.sv
module sdr_rd_top
    import sdr_rd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CAS_LAT = 2,
    parameter int TPC_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [23:0]        req_addr,
    input  logic [TPC_W-1:0]   req_tpc,
    output logic               req_ready,
    output logic               busy,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [15:0]        sd_addr,
    input  logic [DATA_W-1:0]  sd_rdata,
    output logic               word_valid,
    output logic [1:0]         word_idx,
    output logic [DATA_W-1:0]  word_data,
    output logic               done
);

    logic              accept;
    logic              seq_idle;
    logic              act_now;
    logic              rd_now;
    logic              ap_now;
    logic [BANK_W-1:0] cur_bank;
    sdr_cmd_t          cmd;
    logic              blocked;
    logic              lock_active;
    logic              cap_pending;

    assign req_ready = seq_idle && !blocked;
    assign accept    = req_valid && req_ready;

    sdr_rd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_addr (req_addr),
        .idle       (seq_idle),
        .act_now    (act_now),
        .rd_now     (rd_now),
        .ap_now     (ap_now),
        .cur_bank   (cur_bank),
        .cmd_o      (cmd),
        .addr_o     (sd_addr)
    );

    sdr_rd_capture #(
        .DATA_W  (DATA_W),
        .CAS_LAT (CAS_LAT)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .rd_now     (rd_now),
        .rdata      (sd_rdata),
        .word_valid (word_valid),
        .word_idx   (word_idx),
        .word_data  (word_data),
        .done       (done),
        .pending    (cap_pending)
    );

    sdr_bank_guard #(
        .TPC_W (TPC_W)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .start_tpc (req_tpc),
        .ap_now    (ap_now),
        .act_now   (act_now),
        .cur_bank  (cur_bank),
        .req_bank  (bank_of(req_addr)),
        .blocked   (blocked),
        .active    (lock_active)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    assign busy = !seq_idle || cap_pending || word_valid || lock_active;

    a_r9_busy_covers_done: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r9_no_ready_after_take: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !req_ready));

endmodule

// File: tb/sim_sdr_rd_top.sv
module sim_sdr_rd_top;

    localparam int CL = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_tpc = '0;
    logic        req_ready, busy;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [15:0] sd_addr;
    logic [31:0] sd_rdata;
    logic        word_valid, done;
    logic [1:0]  word_idx;
    logic [31:0] word_data;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int last_ap = -100;
    logic [1:0] last_bank = '0;
    int last_w = 0;

    int          due_q[$];
    logic [31:0] dat_q[$];
    int          idx_q[$];

    logic [15:0] open_row = '0;
    logic [31:0] pipe_d [CL+1];

    sdr_rd_top #(.DATA_W(32), .CAS_LAT(CL), .TPC_W(2)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_tpc(req_tpc), .req_ready(req_ready), .busy(busy),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_rdata(sd_rdata), .word_valid(word_valid),
        .word_idx(word_idx), .word_data(word_data), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_word(input logic [23:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic bit is_act();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011;
    endfunction

    function automatic bit is_read();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // memory model: row opened by ACTIVATE, data CL cycles after a READ
    assign sd_rdata = pipe_d[CL];
    always @(negedge clk) begin
        if (is_act()) open_row <= sd_addr;
        pipe_d[0] <= is_read() ? mem_word({open_row, sd_addr[7:0]}) : 32'h0;
        for (int k = 1; k <= CL; k++) pipe_d[k] <= pipe_d[k-1];
    end

    // word and command monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!sd_cs_n)
                check(is_act() || is_read(), "R10 command code",
                      64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'h3);
            if (word_valid) begin
                if (due_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", 64'(word_data), 64'h0);
                end else begin
                    check(cyc == due_q[0], "R5 word timing", 64'(cyc), 64'(due_q[0]));
                    check(word_data == dat_q[0], "R5 word data", 64'(word_data), 64'(dat_q[0]));
                    check(int'(word_idx) == idx_q[0], "R5 word index", 64'(word_idx), 64'(idx_q[0]));
                    check(done == (idx_q[0] == 3), "R6 done pulse", 64'(done), 64'(idx_q[0] == 3));
                    check(busy, "R9 busy with word", 64'(busy), 64'h1);
                    void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(idx_q.pop_front());
                end
            end else begin
                check(!done, "R6 done without word", 64'(done), 64'h0);
                if (due_q.size() != 0 && due_q[0] <= cyc) begin
                    check(1'b0, "R5 missing word", 64'(cyc), 64'(due_q[0]));
                    void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(idx_q.pop_front());
                end
            end
        end
    end

    task automatic do_access(input logic [23:0] a, input logic [1:0] t, input int gap);
        logic [23:0] al;
        int s, r, n;
        al = {a[23:4], 4'b0000};
        repeat (gap) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_tpc   = t;
        s = cyc;
        r = s;
        if (last_ap + 1 > r) r = last_ap + 1;
        if (al[21:20] == last_bank && last_ap + last_w > r) r = last_ap + last_w;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!is_act() && n < 40);
        req_valid = 1'b0;
        req_tpc   = 2'($urandom);
        req_addr  = 24'($urandom);
        if (al[21:20] == last_bank)
            check(cyc == r + 1, "R7 same-bank activate cycle", 64'(cyc), 64'(r + 1));
        else
            check(cyc == r + 1, "R8 other-bank activate cycle", 64'(cyc), 64'(r + 1));
        check(is_act(), "R2 activate command", 64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'h3);
        check(sd_addr == al[23:8], "R2 row address", 64'(sd_addr), 64'(al[23:8]));
        check(busy && !req_ready, "R9 busy during sequence", 64'({busy, req_ready}), 64'h2);
        for (int j = 0; j < 4; j++) begin
            logic [15:0] ec;
            @(negedge clk);
            ec = {al[23:22], al[13], (j == 3), al[11:4], 2'(j), 2'b00};
            check(is_read(), "R3 read command", 64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'h5);
            check(sd_addr == ec, "R4 column address", 64'(sd_addr), 64'(ec));
            due_q.push_back(cyc + CL + 1);
            dat_q.push_back(mem_word(al | 24'(j << 2)));
            idx_q.push_back(j);
        end
        last_ap   = cyc;
        last_bank = al[21:20];
        last_w    = int'(t) + 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int k = 0; k <= CL; k++) pipe_d[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1 reset command NOP",
              64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'hF);
        check(!busy && req_ready, "R1 reset busy/ready", 64'({busy, req_ready}), 64'h1);
        check(!word_valid && !done, "R1 reset word outputs", 64'({word_valid, done}), 64'h0);

        // directed: unaligned low bits, same bank back to back with longest wait
        do_access(24'h5A_3C47, 2'd3, 0);
        do_access(24'h5A_7128, 2'd0, 0);
        // same bank, shortest wait
        do_access(24'h1B_0E90, 2'd1, 0);
        // different bank during a long wait
        do_access(24'h4C_2200, 2'd3, 1);
        do_access(24'h6C_2210, 2'd2, 0);
        do_access(24'hEC_FFF0, 2'd3, 0);
        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [23:0] a;
            a = 24'($urandom);
            if ($urandom % 2 == 0) a[21:20] = last_bank;
            do_access(a, 2'($urandom), int'($urandom % 4));
        end

        repeat (12) @(negedge clk);
        check(due_q.size() == 0, "R5 all words delivered", 64'(due_q.size()), 64'h0);
        check(!busy && req_ready, "R9 busy falls when idle", 64'({busy, req_ready}), 64'h1);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R10 idle NOP",
              64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'hF);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule